// File: doc/BRIEF.md
# Shift-Chain Upset Test Engine

This block measures single-event upsets in ordinary flip-flops. A generator feeds a known serial bit stream into a long chain of shift-register segments. A second generator of the same kind rebuilds that stream, delayed by the chain's full length. Each bit that leaves the far end of the chain is compared with the rebuilt bit, and every mismatch adds one to a saturating error counter. The stream is either a fixed toggling byte pattern or the output of a 32-bit LFSR started from a seed. A host sets the mode, the seed and the run length, then pulses start. It waits for done and reads the count. The engine is clocked from whatever frequency the surrounding system provides, so the same run can be repeated at several rates.

The chain length is segment count times segment length. Both are parameters, so a small chain can be used for simulation and about 38 segments of 512 bits can be used on silicon. An inject input inverts the bit entering the chain in the current cycle. This lets a bench or a bring-up test confirm that the error path works.

Top module: `seu_chain_tester`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and err_count_o is 0.
- R2: When start_i is sampled high while not busy, busy_o is 1, done_o is 0 and err_count_o is 0 in the next cycle. mode_i (0 = fixed pattern, 1 = LFSR), seed_i and run_bits_i are captured at that edge, and later changes to them have no effect on the run.
- R3: With N captured bits and chain length L, busy_o stays high for exactly L+N cycles. Then busy_o falls and done_o rises together. done_o stays high until the next accepted start.
- R4: With inject_i held low, a run ends with err_count_o = 0 in both modes, for any seed and any N. In fixed-pattern mode the stream is bytes 0xAA, 0x55 repeating, sent most significant bit first. In LFSR mode a seed of 0 is replaced by 1.
- R5: Counting busy cycles from 0, if inject_i is high in busy cycle c with c < N, the bit entering the chain is inverted and the final count grows by one. inject_i has no effect in busy cycles with c >= N and no effect while not busy.
- R6: The error counter is CNT_W bits wide and stops at all-ones instead of wrapping.
- R7: A start_i pulse during a run is ignored. The run, its length and its count continue unchanged.
- R8: After done_o rises, err_count_o holds its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, frequency chosen externally |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when not busy |
| mode_i | input | 1 | Stimulus select: 0 fixed pattern, 1 LFSR |
| seed_i | input | 32 | LFSR seed, captured at start |
| run_bits_i | input | BITS_W | Number of bits to compare, captured at start |
| inject_i | input | 1 | Invert the bit entering the chain this cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run has finished |
| err_count_o | output | CNT_W | Saturating mismatch count |

## Verification
If either generator or the chain holds a wrong state, a run with no injection ends with a nonzero count. If the chain has the wrong length, the delayed reference no longer lines up and the count becomes large in LFSR mode. None of this shows until L cycles after start, when comparison begins. A fault in the run-length counter shows as busy lasting a different number of cycles than L+N. A fault in the error path shows as a final count that differs from the number of injected bits that fall inside the compared window. The check is whether the count is exact in that case and capped at the limit during long runs.

// File: rtl/seu_pkg.sv
package seu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    typedef enum logic {
        STIM_PATTERN = 1'b0,
        STIM_RANDOM  = 1'b1
    } stim_mode_t;

    localparam int unsigned LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_FALLBACK = 32'h0000_0001;

    typedef struct packed {
        stim_mode_t        mode;
        logic [LFSR_W-1:0] seed;
    } stim_cfg_t;

    // Fibonacci step, taps 32, 22, 2, 1
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Bit k of the stream AA,55,AA,55... sent MSB first
    function automatic logic pattern_bit(input logic [3:0] k);
        return ~k[0] ^ k[3];
    endfunction

endpackage

// File: rtl/seu_stim_gen.sv
module seu_stim_gen
    import seu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  stim_cfg_t cfg_i,
    input  logic      adv_i,
    output logic      bit_o
);

    stim_mode_t        mode_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic [3:0]        phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= STIM_PATTERN;
            lfsr_q  <= LFSR_FALLBACK;
            phase_q <= '0;
        end else if (load_i) begin
            mode_q  <= cfg_i.mode;
            lfsr_q  <= cfg_i.seed;
            phase_q <= '0;
        end else if (adv_i) begin
            lfsr_q  <= lfsr_step(lfsr_q);
            phase_q <= phase_q + 4'd1;
        end
    end

    always_comb begin
        if (mode_q == STIM_RANDOM) bit_o = lfsr_q[LFSR_W-1];
        else                       bit_o = pattern_bit(phase_q);
    end

endmodule

// File: rtl/seu_shift_segment.sv
module seu_shift_segment #(
    parameter int unsigned SEG_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic d_i,
    output logic q_o
);

    logic [SEG_LEN-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)          stage_q <= '0;
        else if (shift_i) stage_q <= {stage_q[SEG_LEN-2:0], d_i};
    end

    assign q_o = stage_q[SEG_LEN-1];

endmodule

// File: rtl/seu_chain_tester.sv
module seu_chain_tester
    import seu_pkg::*;
#(
    parameter int unsigned SEG_COUNT = 4,
    parameter int unsigned SEG_LEN   = 512,
    parameter int unsigned BITS_W    = 32,
    parameter int unsigned CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [31:0]       seed_i,
    input  logic [BITS_W-1:0] run_bits_i,
    input  logic              inject_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  err_count_o
);

    localparam int unsigned CHAIN_LEN = SEG_COUNT * SEG_LEN;
    localparam int unsigned CYC_W     = BITS_W + 1;
    localparam logic [CYC_W-1:0] FILL_CYC = CYC_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0] ERR_MAX  = {CNT_W{1'b1}};

    run_state_t       state_q;
    logic [CYC_W-1:0] total_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CNT_W-1:0] err_q;

    logic      running, accept, last_cyc, cmp_en;
    logic      src_bit, ref_bit, chain_out;
    stim_cfg_t cfg;
    logic [SEG_COUNT:0] link;

    assign running  = (state_q == ST_RUN);
    assign accept   = start_i && !running;
    assign last_cyc = running && (cyc_q == total_q - CYC_W'(1));
    assign cmp_en   = running && (cyc_q >= FILL_CYC);

    always_comb begin
        cfg.mode = stim_mode_t'(mode_i);
        cfg.seed = (seed_i == '0) ? LFSR_FALLBACK : seed_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            total_q <= '0;
            cyc_q   <= '0;
            err_q   <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            total_q <= {1'b0, run_bits_i} + FILL_CYC;
            cyc_q   <= '0;
            err_q   <= '0;
        end else if (running) begin
            cyc_q <= cyc_q + CYC_W'(1);
            if (last_cyc) state_q <= ST_DONE;
            if (cmp_en && (chain_out != ref_bit) && (err_q != ERR_MAX))
                err_q <= err_q + CNT_W'(1);
        end
    end

    seu_stim_gen u_src (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .cfg_i  (cfg),
        .adv_i  (running),
        .bit_o  (src_bit)
    );

    seu_stim_gen u_ref (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .cfg_i  (cfg),
        .adv_i  (cmp_en),
        .bit_o  (ref_bit)
    );

    assign link[0] = src_bit ^ (running & inject_i);

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        seu_shift_segment #(.SEG_LEN(SEG_LEN)) u_seg (
            .clk     (clk),
            .rst     (rst),
            .shift_i (running),
            .d_i     (link[g]),
            .q_o     (link[g+1])
        );
    end

    assign chain_out   = link[SEG_COUNT];
    assign busy_o      = running;
    assign done_o      = (state_q == ST_DONE);
    assign err_count_o = err_q;

endmodule

// File: rtl/seu_chain_checker.sv
module seu_chain_checker #(
    parameter int unsigned CHAIN_LEN = 2048,
    parameter int unsigned BITS_W    = 32,
    parameter int unsigned CNT_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [BITS_W-1:0] run_bits_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  err_count_o
);

    localparam int unsigned W = BITS_W + 2;

    logic [W-1:0] busy_len;
    logic [W-1:0] want_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            want_len <= '0;
        end else if (start_i && !busy_o) begin
            busy_len <= '0;
            want_len <= W'(run_bits_i) + W'(CHAIN_LEN);
        end else if (busy_o) begin
            busy_len <= busy_len + W'(1);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !done_o && err_count_o == '0));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !done_o && err_count_o == '0));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o && busy_len == want_len));

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R6
    err_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start_i) |=> (err_count_o >= $past(err_count_o)));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && busy_len + W'(1) < want_len) |=> busy_o);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(err_count_o));

endmodule

bind seu_chain_tester seu_chain_checker #(
    .CHAIN_LEN (CHAIN_LEN),
    .BITS_W    (BITS_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .run_bits_i  (run_bits_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_count_o (err_count_o)
);

// File: tb/test_seu_chain_tester.sv
`timescale 1ns/1ps
module test_seu_chain_tester;

    localparam int SEGS   = 3;
    localparam int SLEN   = 8;
    localparam int BW     = 16;
    localparam int CW     = 6;
    localparam int L      = SEGS * SLEN;
    localparam int ERRMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [31:0]   seed_i = '0;
    logic [BW-1:0] run_bits_i = '0;
    logic          inject_i = 1'b0;
    logic          busy_o, done_o;
    logic [CW-1:0] err_count_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    seu_chain_tester #(
        .SEG_COUNT (SEGS),
        .SEG_LEN   (SLEN),
        .BITS_W    (BW),
        .CNT_W     (CW)
    ) i_seu_chain_tester (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .seed_i      (seed_i),
        .run_bits_i  (run_bits_i),
        .inject_i    (inject_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_count_o (err_count_o)
    );

    function automatic int sat(input int v);
        return (v > ERRMAX) ? ERRMAX : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inj: 0 none, 1 random, 2 always. mid: pulse start during run.
    task automatic run_case(input bit m, input logic [31:0] sd, input int nbits,
                            input int inj, input bit mid);
        int exp_err = 0;
        int busy_bad = 0;
        @(negedge clk);
        mode_i = m; seed_i = sd; run_bits_i = BW'(nbits); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: busy next cycle, count cleared
        check("R2 busy after start", busy_o, 1);
        check("R2 done low after start", done_o, 0);
        check("R2 count cleared", err_count_o, 0);
        // R2: captured config must not follow the inputs
        run_bits_i = BW'($urandom_range(0, 200));
        mode_i = ~m;
        seed_i = $urandom;
        for (int c = 0; c < L + nbits; c++) begin
            bit b;
            case (inj)
                1: b = ($urandom_range(0, 3) == 0);
                2: b = 1'b1;
                default: b = 1'b0;
            endcase
            inject_i = b;
            if (b && c < nbits) exp_err++;
            start_i = (mid && c == 5);
            @(negedge clk);
            if (c + 1 < L + nbits && (!busy_o || done_o)) busy_bad++;
        end
        inject_i = 1'b0;
        start_i  = 1'b0;
        // R3 / R7: exact busy length, then done
        check("R3 R7 busy held for L+N cycles", busy_bad, 0);
        check("R3 done after L+N", done_o, 1);
        check("R3 busy low at end", busy_o, 0);
        // R4 R5 R6: final count
        check("R4 R5 R6 error count", err_count_o, sat(exp_err));
        // R5 R8: idle injection ignored, count and done hold
        for (int k = 0; k < 4; k++) begin
            inject_i = 1'b1;
            @(negedge clk);
        end
        inject_i = 1'b0;
        check("R5 R8 count held after done", err_count_o, sat(exp_err));
        check("R3 done held", done_o, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 busy reset", busy_o, 0);
        check("R1 done reset", done_o, 0);
        check("R1 count reset", err_count_o, 0);
        inject_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        inject_i = 1'b0;
        check("R5 idle inject ignored", err_count_o, 0);

        run_case(1'b0, 32'h0, 40, 0, 1'b0);              // R4 pattern clean
        run_case(1'b1, 32'hDEAD_BEEF, 50, 0, 1'b0);      // R4 LFSR clean
        run_case(1'b1, 32'h0, 33, 0, 1'b0);              // R4 zero seed
        run_case(1'b1, 32'h1234_5678, 60, 1, 1'b0);      // R5 random inject
        run_case(1'b0, 32'h0, 45, 1, 1'b0);              // R5 pattern inject
        run_case(1'b1, 32'hCAFE_0001, 0, 2, 1'b0);       // R5 N=0, nothing compared
        run_case(1'b1, 32'h0BAD_F00D, 100, 2, 1'b0);     // R6 saturation
        run_case(1'b0, 32'h0, 30, 1, 1'b1);              // R7 start mid-run
        for (int r = 0; r < 6; r++) begin
            run_case(1'($urandom_range(0, 1)), $urandom,
                     $urandom_range(1, 120), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule